// File: doc/BRIEF.md
# Vectored Interrupt and Return Stack

This block sits beside the sequencer of a small 4-bit controller whose program counter is 11 bits wide. It watches an active-low interrupt request pin and catches each falling edge into a pending flag. It then decides at which instruction boundary the interrupt may be taken. When it takes the interrupt, it saves the return address on a three-level hardware stack, together with the skip state the core has pending. It then steers the program counter to a fixed vector. The core also uses the same stack for subroutine calls and returns.

The decoder reports two things at each boundary: the class of the instruction that just completed and the class of the one about to start. While two program-transfer instructions follow each other, the interrupt is held off. The same applies while two LBI-type pointer loads follow each other. A return pops the top entry. The saved skip bit comes back with the address, so a skip that was pending when the interrupt hit takes effect on the first instruction after the return. Taking an interrupt disables further interrupts until software issues the enable command, which it may do immediately before the return.

Top module: `intr_stack_ctl`

## Requirements
- R1: After reset, `int_en` is 0 and `irq_ack` is 0. Every stack entry holds address 0 with skip 0, so `tgt_pc` reads 0 and `tgt_skip` reads 0.
- R2: A falling edge on `irq_n` seen while `int_en` is 1 makes a request pending. At the next cycle with `instr_done` high and no chain hold, `irq_ack` is 1 in that cycle and `tgt_pc` reads 11'h0FF with `tgt_skip` 0.
- R3: A falling edge on `irq_n` seen while `int_en` is 0 is dropped. Enabling later and reaching a boundary gives no acknowledge.
- R4: On acknowledge, the word {`pc_in`, `skip_in`} is pushed. From the next cycle `tgt_pc`/`tgt_skip` show that address and skip bit. A pop then exposes the entry below.
- R5: Acknowledge clears `int_en` on the following cycle. `ei_set` sets `int_en` on the following cycle. When both occur in the same cycle, acknowledge wins.
- R6: `irq_ack` is never 1 in a cycle where `instr_done` is 0. A pending request waits for a boundary.
- R7: No acknowledge at a boundary where `done_xfer` and `next_xfer` are both 1. It is given at the first boundary of the chain where they are not both 1.
- R8: No acknowledge at a boundary where `done_lbi` and `next_lbi` are both 1. It is given once that pair is broken.
- R9: The stack is last-in first-out with three levels. A push onto a full stack discards the oldest entry.
- R10: Popping past the last valid level keeps returning the bottom entry unchanged.
- R11: Acknowledge takes precedence over a `push` in the same cycle, and that push is dropped. When `push` and `pop` are both high, only the push happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | 1 | Interrupt request, falling edge active |
| instr_done | input | 1 | Instruction boundary strobe |
| done_xfer | input | 1 | Completed instruction is a program transfer |
| next_xfer | input | 1 | Following instruction is a program transfer |
| done_lbi | input | 1 | Completed instruction is an LBI-type load |
| next_lbi | input | 1 | Following instruction is an LBI-type load |
| ei_set | input | 1 | Interrupt enable command |
| push | input | 1 | Subroutine call push |
| pop | input | 1 | Return pop |
| pc_in | input | 11 | Return address to save |
| skip_in | input | 1 | Pending skip state to save |
| irq_ack | output | 1 | Interrupt acknowledged this cycle |
| tgt_pc | output | 11 | Vector during acknowledge, else top-of-stack address |
| tgt_skip | output | 1 | Top-of-stack skip bit (0 during acknowledge) |
| int_en | output | 1 | Interrupt enable state |

## Verification
`irq_ack`, `tgt_pc` and `tgt_skip` are combinational in the acknowledge cycle. The bench therefore drives a boundary on the falling clock edge and samples them in that same cycle, before the rising edge. The stack contents and `int_en` change on the rising edge after a push, pop, acknowledge or enable. The bench checks them in the following cycle. A falling edge on `irq_n` becomes pending at the first rising edge that sees the low level, so the earliest acknowledge is one cycle after the edge. The reference model in the bench updates at each rising edge with the inputs it drove, so every comparison is made against the state that was due in that cycle.

// File: rtl/intr_stack_ctl.sv
module intr_stack_ctl #(
  parameter int AW = 11,
  parameter int DEPTH = 3,
  parameter logic [AW-1:0] VEC = 11'h0FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_n,
  input  logic          instr_done,
  input  logic          done_xfer,
  input  logic          next_xfer,
  input  logic          done_lbi,
  input  logic          next_lbi,
  input  logic          ei_set,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] pc_in,
  input  logic          skip_in,
  output logic          irq_ack,
  output logic [AW-1:0] tgt_pc,
  output logic          tgt_skip,
  output logic          int_en
);
  localparam int EW = AW + 1;

  logic          irq_q, pend, en;
  logic [EW-1:0] stk [DEPTH];

  wire fall       = irq_q & ~irq_n;
  wire chain_hold = (done_xfer & next_xfer) | (done_lbi & next_lbi);
  wire do_push    = irq_ack | push;
  wire do_pop     = pop & ~do_push;
  wire [EW-1:0] new_word = {pc_in, skip_in};

  assign irq_ack  = pend & en & instr_done & ~chain_hold;
  assign tgt_pc   = irq_ack ? VEC : stk[0][EW-1:1];
  assign tgt_skip = irq_ack ? 1'b0 : stk[0][0];
  assign int_en   = en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b1;
      pend  <= 1'b0;
      en    <= 1'b0;
    end else begin
      irq_q <= irq_n;
      if (irq_ack)        pend <= 1'b0;
      else if (fall & en) pend <= 1'b1;
      if (irq_ack)     en <= 1'b0;
      else if (ei_set) en <= 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    logic [EW-1:0] from_above, from_below;
    if (i == 0) begin : g_top
      assign from_above = new_word;
    end else begin : g_mid
      assign from_above = stk[i-1];
    end
    if (i == DEPTH - 1) begin : g_bot
      assign from_below = stk[i];
    end else begin : g_up
      assign from_below = stk[i+1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)       stk[i] <= '0;
      else if (do_push) stk[i] <= from_above;
      else if (do_pop)  stk[i] <= from_below;
    end
  end
endmodule

module intr_stack_ctl_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          instr_done,
  input logic          done_xfer,
  input logic          next_xfer,
  input logic          done_lbi,
  input logic          next_lbi,
  input logic [AW-1:0] pc_in,
  input logic          skip_in,
  input logic          irq_ack,
  input logic [AW-1:0] tgt_pc,
  input logic          tgt_skip,
  input logic          int_en
);
  a_r5_ack_disables: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !int_en);
  a_r4_saved_word: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (tgt_pc == $past(pc_in) && tgt_skip == $past(skip_in)));
  a_r6_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> instr_done);
  a_r7_xfer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_xfer && next_xfer) |-> !irq_ack);
  a_r8_lbi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_lbi && next_lbi) |-> !irq_ack);
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> !irq_ack);
endmodule

bind intr_stack_ctl intr_stack_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_done(instr_done),
  .done_xfer(done_xfer), .next_xfer(next_xfer),
  .done_lbi(done_lbi), .next_lbi(next_lbi),
  .pc_in(pc_in), .skip_in(skip_in), .irq_ack(irq_ack),
  .tgt_pc(tgt_pc), .tgt_skip(tgt_skip), .int_en(int_en)
);

// File: tb/intr_stack_ctl_bench.sv
module intr_stack_ctl_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, irq_n, instr_done, done_xfer, next_xfer, done_lbi, next_lbi;
  logic ei_set, push, pop, skip_in;
  logic [10:0] pc_in;
  logic irq_ack, tgt_skip, int_en;
  logic [10:0] tgt_pc;

  intr_stack_ctl u_intr_stack_ctl (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .instr_done(instr_done),
    .done_xfer(done_xfer), .next_xfer(next_xfer), .done_lbi(done_lbi),
    .next_lbi(next_lbi), .ei_set(ei_set), .push(push), .pop(pop),
    .pc_in(pc_in), .skip_in(skip_in), .irq_ack(irq_ack), .tgt_pc(tgt_pc),
    .tgt_skip(tgt_skip), .int_en(int_en));

  // staged stimulus
  logic s_irq, s_done, s_dx, s_nx, s_dl, s_nl, s_ei, s_push, s_pop, s_skip;
  logic [10:0] s_pc;
  // reference model
  logic m_irq_q, m_pend, m_en;
  logic [11:0] m_stk [3];
  int checks = 0, errors = 0;

  function automatic logic exp_ack();
    return m_pend & m_en & s_done & !((s_dx & s_nx) | (s_dl & s_nl));
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    s_done = 0; s_dx = 0; s_nx = 0; s_dl = 0; s_nl = 0;
    s_ei = 0; s_push = 0; s_pop = 0; s_skip = 0; s_pc = '0;
  endtask

  task automatic model_reset();
    m_irq_q = 1; m_pend = 0; m_en = 0;
    for (int i = 0; i < 3; i++) m_stk[i] = '0;
  endtask

  task automatic step(string tag);
    logic ea, fall;
    @(negedge clk);
    irq_n = s_irq; instr_done = s_done; done_xfer = s_dx; next_xfer = s_nx;
    done_lbi = s_dl; next_lbi = s_nl; ei_set = s_ei; push = s_push;
    pop = s_pop; pc_in = s_pc; skip_in = s_skip;
    #2;
    ea = exp_ack();
    chk(tag, "irq_ack", int'(irq_ack), int'(ea));
    chk(tag, "tgt_pc", int'(tgt_pc), ea ? 'h0FF : int'(m_stk[0][11:1]));
    chk(tag, "tgt_skip", int'(tgt_skip), ea ? 0 : int'(m_stk[0][0]));
    chk(tag, "int_en", int'(int_en), int'(m_en));
    @(posedge clk);
    fall = m_irq_q & !s_irq;
    m_irq_q = s_irq;
    if (ea) m_pend = 0; else if (fall && m_en) m_pend = 1;
    if (ea) m_en = 0; else if (s_ei) m_en = 1;
    if (ea || s_push) begin
      m_stk[2] = m_stk[1]; m_stk[1] = m_stk[0]; m_stk[0] = {s_pc, s_skip};
    end else if (s_pop) begin
      m_stk[0] = m_stk[1]; m_stk[1] = m_stk[2];
    end
  endtask

  task automatic fire_edge(string tag);
    s_irq = 0; step(tag);
    s_irq = 1; step(tag);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    s_irq = 1; idle();
    rst_n = 0;
    irq_n = 1; instr_done = 0; done_xfer = 0; next_xfer = 0; done_lbi = 0;
    next_lbi = 0; ei_set = 0; push = 0; pop = 0; pc_in = '0; skip_in = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    model_reset();
    step("R1");

    // R3: edge while disabled is dropped
    fire_edge("R3");
    s_ei = 1; step("R3"); idle();
    s_done = 1; step("R3"); step("R3"); idle();

    // R6 then R2: pending waits for boundary
    fire_edge("R2");
    step("R6"); step("R6");
    s_done = 1; s_pc = 11'h123; s_skip = 1; step("R2"); idle();
    // R4 / R5: saved word visible, enable cleared
    step("R4"); step("R5");
    s_pop = 1; step("R4"); idle(); step("R4");

    // R5: ack and ei_set same cycle, ack wins
    s_ei = 1; step("R5"); idle();
    fire_edge("R5");
    s_done = 1; s_ei = 1; s_pc = 11'h055; step("R5"); idle();
    step("R5");
    s_ei = 1; step("R5"); idle(); step("R5");

    // R7: transfer chain holds acknowledge
    fire_edge("R7");
    s_done = 1; s_dx = 1; s_nx = 1; step("R7"); step("R7");
    s_nx = 0; s_pc = 11'h321; step("R7"); idle(); step("R7");

    // R8: LBI chain holds acknowledge
    s_ei = 1; step("R8"); idle();
    fire_edge("R8");
    s_done = 1; s_dl = 1; s_nl = 1; step("R8");
    s_dl = 0; s_pc = 11'h7AA; s_skip = 1; step("R8"); idle(); step("R8");

    // R9: four pushes drop the oldest, pops are LIFO
    for (int i = 0; i < 4; i++) begin
      s_push = 1; s_pc = 11'h100 + 11'(i); s_skip = i[0]; step("R9");
    end
    idle();
    for (int i = 0; i < 3; i++) begin s_pop = 1; step("R9"); end
    // R10: popping past the bottom returns the bottom entry
    for (int i = 0; i < 2; i++) begin s_pop = 1; step("R10"); end
    idle(); step("R10");

    // R11: push and pop together -> push only; ack beats push
    s_push = 1; s_pop = 1; s_pc = 11'h2F0; step("R11"); idle(); step("R11");
    s_ei = 1; step("R11"); idle();
    fire_edge("R11");
    s_done = 1; s_push = 1; s_pc = 11'h3C3; s_skip = 1; step("R11"); idle();
    s_pop = 1; step("R11"); idle(); step("R11");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      s_irq = ($urandom % 4) != 0;
      s_done = $urandom % 2; s_dx = $urandom % 2; s_nx = $urandom % 2;
      s_dl = $urandom % 3 == 0; s_nl = $urandom % 3 == 0;
      s_ei = $urandom % 5 == 0; s_push = $urandom % 6 == 0;
      s_pop = $urandom % 6 == 0; s_pc = 11'($urandom); s_skip = $urandom % 2;
      step("R2 R7 R8 R9");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule